// File: doc/BRIEF.md
# Mixed-Radix Microsecond Timestamp Counter

This block keeps a free-running time stamp split into three decimal-style fields: tenths of a microsecond (0 to 9), microseconds (0 to 999999) and seconds (32-bit binary). A single-cycle strobe, arriving at ten times the microsecond rate, advances the tenths field. Each field rolls over at its own limit and carries into the next, so software can read elapsed time without any division.

The value is seen as four 16-bit words. A host can preset the counter by writing all four words. The preset takes effect only once the top word is written: that write arms the load, and the next tick applies it. A status output shows that a load is armed and not yet applied. On readback, the access to word 0 takes a copy of the whole value, so words 1 to 3 that are read after it belong to the same instant.

Top module: `usec_stamp_counter`

## Requirements
- R1: After a synchronous active-low reset, all fields are zero, `armed_o` is 0, `rd_data_o` is 0 and the read snapshot is zero.
- R2: A cycle with `tick_i` high and no armed load advances the tenths field by one. Without a tick, the count holds its value.
- R3: The tenths field counts 0 to 9. A tick at 9 returns it to 0 and adds one to the microseconds field.
- R4: The microseconds field counts 0 to 999999. A carry into it at 999999 returns it to 0 and adds one to seconds. Seconds wrap modulo 2^32.
- R5: Word layout, used for both load and readback. Word 0 is microseconds bits 15:0. Word 1 bits 3:0 are microseconds bits 19:16, word 1 bits 7:4 are tenths, and word 1 bits 15:8 read as 0 and are ignored on write. Word 2 is seconds bits 15:0. Word 3 is seconds bits 31:16.
- R6: A write to word 3 sets `armed_o` on the next cycle. It stays set until the first tick after that write, and clears on the cycle after that tick.
- R7: The tick that finds a load armed replaces the whole count with the staged words and does not also increment it.
- R8: When a load is applied, a staged tenths value above 9 becomes 9, and a staged microseconds value above 999999 becomes 999999.
- R9: Writes to words 0, 1 or 2 do not arm a load and do not change the count.
- R10: A read of word 0 returns the live word 0 and captures the whole count. Reads of words 1 to 3 return that captured copy, even if the counter has moved on.
- R11: `rd_data_o` updates on the clock edge that samples `rd_en_i` high, and holds its value while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One strobe per tenth of a microsecond |
| wr_en_i | input | 1 | Write strobe for a staging word |
| wr_idx_i | input | 2 | Index of the word to write (3 arms the load) |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_idx_i | input | 2 | Index of the word to read (0 takes the snapshot) |
| rd_data_o | output | 16 | Registered read data |
| armed_o | output | 1 | A load is armed and waiting for a tick |

## Verification
A wrong carry or a wrong wrap limit is invisible until the lower field reaches its limit. The bench therefore loads values that sit one tick before each rollover and reads them back after a single tick, so the error shows on the next read. A stale or missing snapshot shows only when the counter advances between a word-0 read and a later word read, and a dedicated sequence creates exactly that gap. Errors in the armed state show on `armed_o` one cycle after the write or the tick. They also show at readback, as a count that was either reloaded or incremented when it should not have been.

// File: rtl/usts_pkg.sv
// Package: shared types and word mapping for the mixed-radix timestamp.
// Assumes the fixed field widths below. The word split into four 16-bit
// words is part of the host-visible layout and must not change.
package usts_pkg;
    localparam int TENTH_W   = 4;
    localparam int USEC_W    = 20;
    localparam int SEC_W     = 32;
    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 4;
    localparam int IDX_W     = $clog2(NUM_WORDS);

    typedef struct packed {
        logic [SEC_W-1:0]   sec;
        logic [USEC_W-1:0]  usec;
        logic [TENTH_W-1:0] tenth;
    } stamp_t;

    // Select one host word out of a full stamp.
    function automatic logic [WORD_W-1:0] stamp_word(input stamp_t s,
                                                     input logic [IDX_W-1:0] idx);
        logic [WORD_W-1:0] w;
        case (idx)
            2'd0:    w = s.usec[15:0];
            2'd1:    w = {8'h00, s.tenth, s.usec[19:16]};
            2'd2:    w = s.sec[15:0];
            default: w = s.sec[31:16];
        endcase
        return w;
    endfunction
endpackage

// File: rtl/usts_load_stage.sv
// Module: staging words for a preset, plus the armed flag.
// Each host word is kept in its own register. Only the meaningful bits of
// word 1 are stored. A write to word 3 arms the load. The first tick after
// that write asserts apply_o and disarms. Values are clamped to the field
// limits here, so the counter never holds an out-of-range value.
module usts_load_stage
    import usts_pkg::*;
#(
    parameter int TENTH_LIMIT = 9,
    parameter int USEC_LIMIT  = 999999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output stamp_t            load_val_o,
    output logic              apply_o,
    output logic              armed_o
);
    localparam logic [TENTH_W-1:0] TENTH_MAX = TENTH_W'(TENTH_LIMIT);
    localparam logic [USEC_W-1:0]  USEC_MAX  = USEC_W'(USEC_LIMIT);
    localparam logic [IDX_W-1:0]   TOP_IDX   = IDX_W'(NUM_WORDS - 1);

    logic [15:0]        raw_usec_lo;
    logic [3:0]         raw_usec_hi;
    logic [TENTH_W-1:0] raw_tenth;
    logic [15:0]        raw_sec_lo;
    logic [15:0]        raw_sec_hi;
    logic               top_write;
    logic               armed_q;

    assign top_write = wr_en_i && (wr_idx_i == TOP_IDX);

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        if (gi == 1) begin : g_mid
            logic [7:0] word_q;
            // Keep the tenths nibble and the high microsecond nibble of word 1.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en_i && wr_idx_i == IDX_W'(gi))
                    word_q <= wr_data_i[7:0];
            end
            assign raw_usec_hi = word_q[3:0];
            assign raw_tenth   = word_q[7:4];
        end else begin : g_full
            logic [WORD_W-1:0] word_q;
            // Keep a full 16-bit staging word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    word_q <= '0;
                else if (wr_en_i && wr_idx_i == IDX_W'(gi))
                    word_q <= wr_data_i;
            end
            if (gi == 0) begin : g_w0
                assign raw_usec_lo = word_q;
            end else if (gi == 2) begin : g_w2
                assign raw_sec_lo = word_q;
            end else begin : g_w3
                assign raw_sec_hi = word_q;
            end
        end
    end

    // Clamp the staged fields to their decimal limits.
    always_comb begin
        load_val_o.tenth = (raw_tenth > TENTH_MAX) ? TENTH_MAX : raw_tenth;
        load_val_o.usec  = ({raw_usec_hi, raw_usec_lo} > USEC_MAX)
                           ? USEC_MAX : {raw_usec_hi, raw_usec_lo};
        load_val_o.sec   = {raw_sec_hi, raw_sec_lo};
    end

    // A write to the top word arms the load; the next tick disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (top_write)
            armed_q <= 1'b1;
        else if (tick_i)
            armed_q <= 1'b0;
    end

    assign armed_o = armed_q;
    assign apply_o = armed_q && tick_i;

    p_arm_on_top_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        top_write |=> armed_q);
    p_disarm_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && tick_i && !top_write) |=> !armed_q);
    p_low_write_no_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !top_write) |=> !armed_q);
    p_clamp_tenth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |-> (load_val_o.tenth <= TENTH_MAX));
    p_clamp_usec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |-> (load_val_o.usec <= USEC_MAX));
endmodule

// File: rtl/usts_time_chain.sv
// Module: the three cascaded counting fields.
// The tenths field steps on each tick. Its wrap carries into microseconds,
// and the microsecond wrap carries into seconds. An applied load takes
// priority over counting in the same cycle. Assumes load values are
// already in range.
module usts_time_chain
    import usts_pkg::*;
#(
    parameter int TENTH_LIMIT = 9,
    parameter int USEC_LIMIT  = 999999
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick_i,
    input  logic   apply_i,
    input  stamp_t load_val_i,
    output stamp_t stamp_o
);
    localparam logic [TENTH_W-1:0] TENTH_MAX = TENTH_W'(TENTH_LIMIT);
    localparam logic [USEC_W-1:0]  USEC_MAX  = USEC_W'(USEC_LIMIT);

    stamp_t cnt_q;
    logic   tenth_wrap;
    logic   usec_wrap;

    // Carry terms for the cascade.
    always_comb begin
        tenth_wrap = tick_i && (cnt_q.tenth == TENTH_MAX);
        usec_wrap  = tenth_wrap && (cnt_q.usec == USEC_MAX);
    end

    // Tenths field: load, or step with a wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q.tenth <= '0;
        else if (apply_i)
            cnt_q.tenth <= load_val_i.tenth;
        else if (tenth_wrap)
            cnt_q.tenth <= '0;
        else if (tick_i)
            cnt_q.tenth <= cnt_q.tenth + 1'b1;
    end

    // Microseconds field: load, or take the carry from tenths.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q.usec <= '0;
        else if (apply_i)
            cnt_q.usec <= load_val_i.usec;
        else if (usec_wrap)
            cnt_q.usec <= '0;
        else if (tenth_wrap)
            cnt_q.usec <= cnt_q.usec + 1'b1;
    end

    // Seconds field: load, or take the carry from microseconds (binary wrap).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q.sec <= '0;
        else if (apply_i)
            cnt_q.sec <= load_val_i.sec;
        else if (usec_wrap)
            cnt_q.sec <= cnt_q.sec + 1'b1;
    end

    assign stamp_o = cnt_q;

    p_tenth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.tenth <= TENTH_MAX);
    p_usec_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.usec <= USEC_MAX);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !apply_i && cnt_q.tenth < TENTH_MAX)
        |=> (cnt_q.tenth == $past(cnt_q.tenth) + 1'b1) && $stable(cnt_q.usec));
    p_usec_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !apply_i && cnt_q.tenth == TENTH_MAX && cnt_q.usec == USEC_MAX)
        |=> (cnt_q.usec == '0) && (cnt_q.tenth == '0)
            && (cnt_q.sec == $past(cnt_q.sec) + 1'b1));
    p_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apply_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/usts_read_snap.sv
// Module: registered readback with a snapshot taken on word 0.
// A read of word 0 returns the live word and copies the whole stamp.
// Reads of the other words come from that copy, so a multi-word read
// that starts with word 0 is coherent.
module usts_read_snap
    import usts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  stamp_t            live_i,
    output logic [WORD_W-1:0] rd_data_o
);
    stamp_t            snap_q;
    logic [WORD_W-1:0] rd_q;
    logic              take_snap;

    assign take_snap = rd_en_i && (rd_idx_i == '0);

    // Capture the whole stamp on a word-0 read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (take_snap)
            snap_q <= live_i;
    end

    // Register the selected word on any read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en_i)
            rd_q <= take_snap ? stamp_word(live_i, rd_idx_i)
                              : stamp_word(snap_q, rd_idx_i);
    end

    assign rd_data_o = rd_q;

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
    p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take_snap |=> $stable(snap_q));
    p_word0_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_snap |=> (rd_data_o == $past(live_i.usec[15:0])));
    p_mid_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_idx_i == 2'd1) |=> (rd_data_o[15:8] == 8'h00));
endmodule

// File: rtl/usec_stamp_counter.sv
// Module: top of the mixed-radix microsecond timestamp counter.
// Assumes tick_i is a one-cycle strobe per tenth of a microsecond. The
// host writes words 0..3 with word 3 last; that write arms the load,
// which the following tick applies.
module usec_stamp_counter
    import usts_pkg::*;
#(
    parameter int TENTH_LIMIT = 9,
    parameter int USEC_LIMIT  = 999999
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_idx_i,
    input  logic [15:0] wr_data_i,
    input  logic        rd_en_i,
    input  logic [1:0]  rd_idx_i,
    output logic [15:0] rd_data_o,
    output logic        armed_o
);
    stamp_t load_val;
    stamp_t live;
    logic   apply;

    usts_load_stage #(.TENTH_LIMIT(TENTH_LIMIT), .USEC_LIMIT(USEC_LIMIT)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_en_i    (wr_en_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .load_val_o (load_val),
        .apply_o    (apply),
        .armed_o    (armed_o)
    );

    usts_time_chain #(.TENTH_LIMIT(TENTH_LIMIT), .USEC_LIMIT(USEC_LIMIT)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .apply_i    (apply),
        .load_val_i (load_val),
        .stamp_o    (live)
    );

    usts_read_snap u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_idx_i  (rd_idx_i),
        .live_i    (live),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/tb_usec_stamp_counter.sv
`timescale 1ns/1ps
module tb_usec_stamp_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_idx_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_idx_i = '0;
    logic [15:0] rd_data_o;
    logic        armed_o;

    int checks = 0;
    int failures = 0;

    usec_stamp_counter dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i),
        .rd_data_o(rd_data_o), .armed_o(armed_o)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [15:0] w0, w1, w2, w3;
        logic [15:0] ticks;
        logic [15:0] e0, e1, e2, e3;
    } vec_t;

    // Each vector is a preset, a number of ticks, and the expected words (R5 layout).
    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'd25, 16'h0002, 16'h0050, 16'h0000, 16'h0000}, // R2 R3
        '{16'h423F, 16'h009F, 16'h0005, 16'h0000, 16'd1,  16'h0000, 16'h0000, 16'h0006, 16'h0000}, // R4
        '{16'h423F, 16'h009F, 16'hFFFF, 16'hFFFF, 16'd1,  16'h0000, 16'h0000, 16'h0000, 16'h0000}, // R4 sec wrap
        '{16'hFFFF, 16'hABFF, 16'h5678, 16'h1234, 16'd0,  16'h423F, 16'h009F, 16'h5678, 16'h1234}, // R8
        '{16'hFFFF, 16'h0090, 16'h0007, 16'h0000, 16'd1,  16'h0000, 16'h0001, 16'h0007, 16'h0000}, // R5 nibble carry
        '{16'h0064, 16'h0030, 16'h0001, 16'h0000, 16'd17, 16'h0066, 16'h0000, 16'h0001, 16'h0000}, // R3
        '{16'h423F, 16'h000F, 16'hFFFF, 16'h0000, 16'd10, 16'h0000, 16'h0000, 16'h0000, 16'h0001}  // R4 word2->3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic write_word(input int idx, input logic [15:0] d);
        wr_en_i = 1'b1; wr_idx_i = 2'(idx); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic read_word(input int idx, output logic [15:0] d);
        rd_en_i = 1'b1; rd_idx_i = 2'(idx);
        @(negedge clk);
        rd_en_i = 1'b0;
        d = rd_data_o;
    endtask

    initial begin
        #(5ns * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] r;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 armed", 32'(armed_o), 0);
        check("R1 rd_data", 32'(rd_data_o), 0);
        for (int i = 0; i < 4; i++) begin
            read_word(i, r);
            check("R1 word", 32'(r), 0);
        end

        // Vector table: preset, apply, tick, read back
        for (int v = 0; v < NVEC; v++) begin
            write_word(0, VECS[v].w0);
            write_word(1, VECS[v].w1);
            write_word(2, VECS[v].w2);
            check("R9 not armed before top word", 32'(armed_o), 0);
            write_word(3, VECS[v].w3);
            check("R6 armed after top word", 32'(armed_o), 1);
            ticks(1);
            check("R6 disarmed after tick", 32'(armed_o), 0);
            ticks(int'(VECS[v].ticks));
            read_word(0, r); check("R7/R5 vec w0", 32'(r), 32'(VECS[v].e0));
            read_word(1, r); check("R7/R5 vec w1", 32'(r), 32'(VECS[v].e1));
            read_word(2, r); check("R7/R5 vec w2", 32'(r), 32'(VECS[v].e2));
            read_word(3, r); check("R7/R5 vec w3", 32'(r), 32'(VECS[v].e3));
        end
        // State now: sec=0x10000, usec=0, tenths=0

        // R9: low-word writes neither arm nor change the count
        write_word(0, 16'h1111);
        write_word(1, 16'h0077);
        write_word(2, 16'h2222);
        ticks(3);
        check("R9 armed stays low", 32'(armed_o), 0);
        read_word(0, r); check("R9 w0", 32'(r), 32'h0000);
        read_word(1, r); check("R9 w1", 32'(r), 32'h0030);
        read_word(3, r); check("R9 w3", 32'(r), 32'h0001);

        // R2: no tick means no change
        idle(20);
        read_word(0, r); check("R2 hold w0", 32'(r), 32'h0000);
        read_word(1, r); check("R2 hold w1", 32'(r), 32'h0030);

        // R10: snapshot stays coherent while the counter runs
        read_word(0, r); check("R10 w0 live", 32'(r), 32'h0000);
        ticks(15);
        read_word(1, r); check("R10 w1 from snapshot", 32'(r), 32'h0030);
        read_word(0, r); check("R10 w0 new snapshot", 32'(r), 32'h0001);
        read_word(1, r); check("R10 w1 new snapshot", 32'(r), 32'h0080);

        // R11: output holds without a read strobe
        ticks(5);
        idle(3);
        check("R11 hold", 32'(rd_data_o), 32'h0080);

        // R6: armed persists until a tick, then the load applies (R7)
        write_word(0, 16'h0010);
        write_word(1, 16'h0020);
        write_word(2, 16'h0030);
        write_word(3, 16'h0040);
        idle(6);
        check("R6 armed persists", 32'(armed_o), 1);
        read_word(0, r); check("R7 no load without tick", 32'(r), 32'h0002);
        ticks(1);
        check("R6 cleared", 32'(armed_o), 0);
        read_word(0, r); check("R7 loaded w0", 32'(r), 32'h0010);
        read_word(1, r); check("R7 loaded w1 no increment", 32'(r), 32'h0020);
        read_word(3, r); check("R7 loaded w3", 32'(r), 32'h0040);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 armed after reset", 32'(armed_o), 0);
        read_word(2, r); check("R1 snapshot cleared", 32'(r), 32'h0000);
        read_word(0, r); check("R1 count cleared", 32'(r), 32'h0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule